// File: doc/BRIEF.md
# K2 Line Status Filter with Line AIS and RDI Detection

This block watches the three low-order bits of the K2 line overhead byte once per received frame. It keeps these bits apart from the protection-switching bits in the upper part of the byte. A persistence filter accepts a new 3-bit status only after the same value has arrived in a programmable number of back-to-back frames. Each time the accepted status changes, an event is raised, and a mask decides whether that event reaches the interrupt output.

Two flags come from the same bits. Line AIS is the code 111 and remote defect indication is the code 110. Each flag sets once its code has been seen in N frames in a row. It clears once N frames in a row have arrived without the code. The status filter and both flags share one threshold N. While the framer reports loss of frame, arriving frames are ignored and every run counter is held at zero. The accepted status and the flags keep their values until a fresh run completes.

Top module: `k2_line_status_mon`

## Requirements
- R1: After reset, k2Status is 000 and aisLine, rdiLine and irq are 0.
- R2: k2Status takes the value of k2Byte[2:0] on the clock edge of the N-th consecutive valid frame that carries that value and differs from the current status. It is unchanged after N-1 such frames. k2Byte[7:3] has no effect.
- R3: When k2Status changes, irq is 1 for exactly the one cycle in which the new status first appears, provided deltaMask was 0 at that frame. With deltaMask at 1, irq stays 0.
- R4: aisLine rises on the N-th consecutive valid frame whose k2Byte[2:0] equals 111, and not on the (N-1)-th.
- R5: Once set, aisLine falls on the N-th consecutive valid frame whose k2Byte[2:0] is not 111. A frame carrying 111 restarts that count.
- R6: rdiLine follows the same set and clear rule as aisLine, using the code 110.
- R7: A frame presented while oofFlag is 1 is ignored, and every run count restarts from zero. k2Status, aisLine and rdiLine hold their values.
- R8: A persistN value of 0 acts as 1, so a single frame is enough to change status or a flag.
- R9: A frame carrying a different value breaks a status run. The count for the new value starts again at one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle strobe that marks a received K2 byte |
| k2Byte | input | 8 | Received K2 byte; only bits [2:0] are used |
| oofFlag | input | 1 | Framer reports loss of frame |
| persistN | input | 4 | Consecutive-frame threshold N (0 acts as 1) |
| deltaMask | input | 1 | 1 blocks the status-change interrupt |
| k2Status | output | 3 | Accepted K2[2:0] status |
| aisLine | output | 1 | Line AIS detected |
| rdiLine | output | 1 | Line RDI detected |
| irq | output | 1 | One-cycle status-change interrupt |

## Verification
The bench uses the default parameters: a 4-bit threshold, with AIS code 111 and RDI code 110. This puts every threshold corner within reach: 0 acting as 1, the typical value 4, and the largest value 15, where the run counter runs up to its top value. With persistN set to 4 and to 15, the bench checks status, set and clear timing at exactly N-1 and N frames. It also breaks runs with a differing frame and with a loss-of-frame frame, and it fills the upper K2 bits with random values.

// File: rtl/k2mon_pkg.sv
package k2mon_pkg;
  localparam int K2_BITS = 3;

  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic loadCand;
    logic loadStatus;
    logic toggleAis;
    logic toggleRdi;
  } k2StrobeT;
endpackage

// File: rtl/k2mon_ctrl.sv
module k2mon_ctrl
  import k2mon_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter logic [K2_BITS-1:0] AIS_PAT = 3'b111,
  parameter logic [K2_BITS-1:0] RDI_PAT = 3'b110
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic               oofFlag,
  input  logic [K2_BITS-1:0] k2Bits,
  input  logic [CNT_W-1:0]   persistN,
  input  logic [K2_BITS-1:0] candBits,
  input  logic [K2_BITS-1:0] statusBits,
  input  logic               aisFlag,
  input  logic               rdiFlag,
  output k2StrobeT           strobe
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             sample;
  logic [CNT_W-1:0] nEff;
  logic [CNT_W-1:0] stsRun, stsRunNext;
  logic [1:0]       flagNow, flagToggle;

  assign sample = frameValid && !oofFlag;
  assign nEff   = (persistN == '0) ? CNT_ONE : persistN;
  assign flagNow = {rdiFlag, aisFlag};

  // Status persistence run
  always_comb begin
    if (k2Bits == candBits && stsRun != '0)
      stsRunNext = (stsRun == CNT_MAX) ? stsRun : stsRun + CNT_ONE;
    else
      stsRunNext = CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN || oofFlag) stsRun <= '0;
    else if (sample)      stsRun <= stsRunNext;
  end

  // Symmetric hysteresis counters for each defect code
  for (genvar g = 0; g < 2; g++) begin : gFlag
    localparam logic [K2_BITS-1:0] PAT = (g == 0) ? AIS_PAT : RDI_PAT;
    logic [CNT_W-1:0] run, runNext;
    logic             differs;

    assign differs = ((k2Bits == PAT) != flagNow[g]);
    always_comb begin
      if (!differs)             runNext = '0;
      else if (run == CNT_MAX)  runNext = run;
      else                      runNext = run + CNT_ONE;
    end
    assign flagToggle[g] = sample && differs && (runNext >= nEff);

    always_ff @(posedge clk) begin
      if (!rstN || oofFlag) run <= '0;
      else if (sample)      run <= flagToggle[g] ? '0 : runNext;
    end
  end

  always_comb begin
    strobe.loadCand   = sample;
    strobe.loadStatus = sample && (stsRunNext >= nEff) && (k2Bits != statusBits);
    strobe.toggleAis  = flagToggle[0];
    strobe.toggleRdi  = flagToggle[1];
  end
endmodule

// File: rtl/k2mon_dp.sv
module k2mon_dp
  import k2mon_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [K2_BITS-1:0] k2Bits,
  input  logic               deltaMask,
  input  k2StrobeT           strobe,
  output logic [K2_BITS-1:0] candBits,
  output logic [K2_BITS-1:0] statusBits,
  output logic               aisFlag,
  output logic               rdiFlag,
  output logic               irqOut
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      candBits   <= '0;
      statusBits <= '0;
      aisFlag    <= 1'b0;
      rdiFlag    <= 1'b0;
      irqOut     <= 1'b0;
    end else begin
      if (strobe.loadCand)   candBits   <= k2Bits;
      if (strobe.loadStatus) statusBits <= k2Bits;
      if (strobe.toggleAis)  aisFlag    <= !aisFlag;
      if (strobe.toggleRdi)  rdiFlag    <= !rdiFlag;
      irqOut <= strobe.loadStatus && !deltaMask;
    end
  end
endmodule

// File: rtl/k2_line_status_mon.sv
module k2_line_status_mon
  import k2mon_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter logic [K2_BITS-1:0] AIS_PAT = 3'b111,
  parameter logic [K2_BITS-1:0] RDI_PAT = 3'b110
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic [7:0]         k2Byte,
  input  logic               oofFlag,
  input  logic [CNT_W-1:0]   persistN,
  input  logic               deltaMask,
  output logic [K2_BITS-1:0] k2Status,
  output logic               aisLine,
  output logic               rdiLine,
  output logic               irq
);
  k2StrobeT           strobe;
  logic [K2_BITS-1:0] k2Bits, candBits;
  logic               unusedHighBits;

  assign k2Bits         = k2Byte[K2_BITS-1:0];
  assign unusedHighBits = ^k2Byte[7:K2_BITS];

  k2mon_ctrl #(.CNT_W(CNT_W), .AIS_PAT(AIS_PAT), .RDI_PAT(RDI_PAT)) uCtrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .oofFlag(oofFlag),
    .k2Bits(k2Bits), .persistN(persistN), .candBits(candBits),
    .statusBits(k2Status), .aisFlag(aisLine), .rdiFlag(rdiLine),
    .strobe(strobe)
  );

  k2mon_dp uDp (
    .clk(clk), .rstN(rstN), .k2Bits(k2Bits), .deltaMask(deltaMask),
    .strobe(strobe), .candBits(candBits), .statusBits(k2Status),
    .aisFlag(aisLine), .rdiFlag(rdiLine), .irqOut(irq)
  );
endmodule

// File: rtl/k2_line_status_mon_chk.sv
module k2_line_status_mon_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameValid,
  input logic [7:0] k2Byte,
  input logic       oofFlag,
  input logic       deltaMask,
  input logic [2:0] k2Status,
  input logic       aisLine,
  input logic       rdiLine,
  input logic       irq
);
  AST_STATUS_ON_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(k2Status) |-> $past(frameValid && !oofFlag)); // R2
  AST_STATUS_FROM_BITS: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(k2Status) |-> k2Status == $past(k2Byte[2:0])); // R2
  AST_IRQ_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !$stable(k2Status)); // R3
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(k2Status) |-> irq == !$past(deltaMask)); // R3
  AST_AIS_SET_CODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aisLine) |-> $past(frameValid && !oofFlag && k2Byte[2:0] == 3'b111)); // R4
  AST_AIS_CLEAR_CODE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aisLine) |-> $past(frameValid && !oofFlag && k2Byte[2:0] != 3'b111)); // R5
  AST_RDI_SET_CODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdiLine) |-> $past(frameValid && !oofFlag && k2Byte[2:0] == 3'b110)); // R6
  AST_RDI_CLEAR_CODE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdiLine) |-> $past(frameValid && !oofFlag && k2Byte[2:0] != 3'b110)); // R6
  AST_OOF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(oofFlag) |-> ($stable(k2Status) && $stable(aisLine) && $stable(rdiLine))); // R7
endmodule

bind k2_line_status_mon k2_line_status_mon_chk uChk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .k2Byte(k2Byte),
  .oofFlag(oofFlag), .deltaMask(deltaMask), .k2Status(k2Status),
  .aisLine(aisLine), .rdiLine(rdiLine), .irq(irq)
);

// File: tb/k2_line_status_mon_test.sv
module k2_line_status_mon_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameValid = 1'b0;
  logic [7:0] k2Byte = '0;
  logic       oofFlag = 1'b0;
  logic [3:0] persistN = 4'd4;
  logic       deltaMask = 1'b0;
  logic [2:0] k2Status;
  logic       aisLine, rdiLine, irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  k2_line_status_mon uut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .k2Byte(k2Byte),
    .oofFlag(oofFlag), .persistN(persistN), .deltaMask(deltaMask),
    .k2Status(k2Status), .aisLine(aisLine), .rdiLine(rdiLine), .irq(irq)
  );

  typedef struct {
    logic [2:0] st;
    bit         ais;
    bit         rdi;
    bit         irqE;
    string      tag;
  } expT;
  expT expQ[$];

  // Expected-behaviour model built from the requirements
  int mStRun = 0, mAisRun = 0, mRdiRun = 0;
  logic [2:0] mCand = '0, mSt = '0;
  bit mAis = 0, mRdi = 0;

  function automatic logic [7:0] mk(input logic [2:0] b);
    logic [4:0] hi = 5'($urandom);
    return {hi, b};
  endfunction

  task automatic frame(input logic [2:0] b, input bit oof, input string tag);
    int nEff;
    bit m, irqE;
    expT e;
    @(negedge clk);
    frameValid = 1'b1; k2Byte = mk(b); oofFlag = oof;
    @(posedge clk);
    nEff = (persistN == 0) ? 1 : int'(persistN);
    irqE = 0;
    if (oof) begin
      mStRun = 0; mAisRun = 0; mRdiRun = 0;
    end else begin
      mStRun = (b == mCand && mStRun > 0) ? ((mStRun < 15) ? mStRun + 1 : 15) : 1;
      mCand = b;
      if (mStRun >= nEff && b != mSt) begin mSt = b; irqE = !deltaMask; end
      m = (b == 3'b111);
      if (m != mAis) begin
        mAisRun++;
        if (mAisRun >= nEff) begin mAis = !mAis; mAisRun = 0; end
      end else mAisRun = 0;
      m = (b == 3'b110);
      if (m != mRdi) begin
        mRdiRun++;
        if (mRdiRun >= nEff) begin mRdi = !mRdi; mRdiRun = 0; end
      end else mRdiRun = 0;
    end
    e.st = mSt; e.ais = mAis; e.rdi = mRdi; e.irqE = irqE; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    frameValid = 1'b0; oofFlag = 1'b0; k2Byte = 8'($urandom);
  endtask

  task automatic frames(input int n, input logic [2:0] b, input string tag);
    for (int i = 0; i < n; i++) frame(b, 1'b0, tag);
  endtask

  // Monitor: compares outputs one cycle after each frame edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      checks++;
      if (k2Status !== e.st || aisLine !== e.ais || rdiLine !== e.rdi || irq !== e.irqE) begin
        failures++;
        $display("FAIL %s: got st=%b ais=%b rdi=%b irq=%b, expected st=%b ais=%b rdi=%b irq=%b",
                 e.tag, k2Status, aisLine, rdiLine, irq, e.st, e.ais, e.rdi, e.irqE);
      end
    end
  end

  task automatic directCheck(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    directCheck(k2Status === 3'b000 && !aisLine && !rdiLine && !irq, "R1",
                $sformatf("reset got st=%b ais=%b rdi=%b irq=%b expected 000 0 0 0",
                          k2Status, aisLine, rdiLine, irq));

    // R2: N-1 frames then the N-th frame, upper bits random
    persistN = 4'd4;
    frames(3, 3'b101, "R2 n-1");
    frames(1, 3'b101, "R2 R3 n");
    frames(2, 3'b101, "R2 steady");
    // R9: run broken by a differing value
    frames(2, 3'b010, "R9 run");
    frames(1, 3'b011, "R9 break");
    frames(3, 3'b010, "R9 restart n-1");
    frames(1, 3'b010, "R9 restart n");
    // R3: masked change
    deltaMask = 1'b1;
    frames(4, 3'b001, "R3 masked");
    deltaMask = 1'b0;
    // R4 / R5: AIS set and clear
    frames(3, 3'b111, "R4 n-1");
    frames(1, 3'b111, "R4 n");
    frames(3, 3'b000, "R5 n-1");
    frames(1, 3'b111, "R5 restart");
    frames(3, 3'b000, "R5 n-1 again");
    frames(1, 3'b000, "R5 n");
    // R6: RDI set and clear
    frames(3, 3'b110, "R6 set n-1");
    frames(1, 3'b110, "R6 set n");
    frames(3, 3'b100, "R6 clear n-1");
    frames(1, 3'b100, "R6 clear n");
    // R7: loss of frame restarts runs, flags hold
    frames(3, 3'b111, "R7 pre");
    frame(3'b111, 1'b1, "R7 oof ignored");
    frames(3, 3'b111, "R7 after n-1");
    frames(1, 3'b111, "R7 after n");
    frame(3'b000, 1'b1, "R7 oof hold");
    frames(4, 3'b000, "R7 clear");
    // R8: threshold zero acts as one
    persistN = 4'd0;
    frames(1, 3'b111, "R8 ais set");
    frames(1, 3'b011, "R8 ais clear");
    frames(1, 3'b110, "R8 rdi set");
    // Largest threshold
    persistN = 4'd15;
    frames(14, 3'b010, "R2 max n-1");
    frames(1, 3'b010, "R2 max n");
    frames(14, 3'b111, "R4 max n-1");
    frames(1, 3'b111, "R4 max n");
    frames(20, 3'b111, "R4 max hold");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule